// File: doc/BRIEF.md
# Bridge Driver Fault and Sleep Supervisor

This block supervises a pair of full-bridge motor controllers. It takes an active-low sleep request and a set of digital fault flags: load-supply undervoltage, gate-supply undervoltage, over-temperature and one overcurrent flag per bridge. From these it drives a single output enable that both bridges share, an enable for the gate-supply charge pump, and three status bits.

After a power-on reset or a wake from sleep, the charge pump runs for a fixed settling window of `SETTLE_CYCLES` clocks, and the bridges stay off for that time. The default is 20000 cycles, about 200 µs at 100 MHz.

The faults fall into two kinds:
- **Self-clearing faults.** Thermal and undervoltage faults disable the outputs only while their flag is high.
- **Latched fault.** An overcurrent on either bridge is a short-circuit event. It is latched, and it keeps both bridges off until the part goes to sleep or is reset.

Threshold detection, hysteresis and the charge pump itself live outside the block.

Top module: `mdrv_supervisor`

## Requirements
- R1: While `rst_n` is low, and for the first two rising edges after it rises, the block holds its reset state: `out_en`=0, `pump_en`=1, `stat_oc_latched`=0, settling counter at zero.
- R2: After reset release, `out_en` stays 0 for exactly `SETTLE_CYCLES` active clock edges. It may rise only after the edge that ends the window.
- R3: `sleep_req_n`=0 drives `out_en` to 0 in the same cycle. It drives `pump_en` to 0 from the next rising edge.
- R4: The first edge that sees `sleep_req_n`=1 while asleep sets `pump_en`=1 and starts a new settling window of `SETTLE_CYCLES` edges. `out_en` stays 0 for that window.
- R5: If sleep is requested again during a settling window, the window is cancelled. The next wake starts it from zero.
- R6: Any bit of `oc_flag` at 1 forces `out_en` to 0 in the same cycle. It sets `stat_oc_latched` at the next edge. Outputs stay off after the flag returns to 0.
- R7: The overcurrent latch clears only on reset or at an edge where `sleep_req_n`=0. An `oc_flag` seen while sleep is requested does not set it.
- R8: `over_temp`=1 forces `out_en` to 0 only while it is high, with no latching. `stat_thermal` equals `over_temp`.
- R9: `vbb_uv`=1 or `vcp_uv`=1 forces `out_en` to 0 only while high. `stat_uv` is their OR. Recovery needs no new settling window.
- R10: `out_en` is 1 exactly when all of the following hold: sleep is not requested, settling is complete, no undervoltage, no over-temperature, no live overcurrent flag, and no latched overcurrent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| sleep_req_n | input | 1 | Active-low sleep request |
| vbb_uv | input | 1 | Load-supply undervoltage flag |
| vcp_uv | input | 1 | Gate-supply undervoltage flag |
| over_temp | input | 1 | Over-temperature flag |
| oc_flag | input | NUM_BRIDGES | Per-bridge overcurrent flags |
| out_en | output | 1 | Shared bridge output enable |
| pump_en | output | 1 | Charge-pump enable |
| stat_oc_latched | output | 1 | Latched overcurrent status |
| stat_thermal | output | 1 | Active thermal fault status |
| stat_uv | output | 1 | Active undervoltage status |

## Verification
Each result has a fixed due time after its stimulus:
- **Same cycle:** the gating of `out_en` by sleep, faults or overcurrent, and the two live status bits.
- **Next rising edge:** `pump_en` and `stat_oc_latched`.
- **After the settling window:** the end of settling, `SETTLE_CYCLES` edges after the first awake edge, with two extra edges after reset for the reset synchronizer.

The bench changes inputs only on falling edges. At each rising edge it advances a behavioural model, then compares all outputs 2 ns later. By then the design's registers have settled and the inputs are still steady, so every comparison falls in the cycle in which the result is due.

// File: rtl/mdrv_pkg.sv
package mdrv_pkg;
  typedef enum logic [1:0] {
    PH_SLEEP  = 2'd0,
    PH_SETTLE = 2'd1,
    PH_RUN    = 2'd2
  } phase_e;
endpackage

// File: rtl/mdrv_rst_sync.sv
// Asynchronous assert, synchronous release of the active-low reset.
module mdrv_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/mdrv_settle_seq.sv
// Sleep / settle / run sequencer with the charge-pump settling counter.
module mdrv_settle_seq
  import mdrv_pkg::*;
#(
  parameter int SETTLE_CYCLES = 20000
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   sleep_n,
  output phase_e phase,
  output logic   pump_en
);
  localparam int CW = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(SETTLE_CYCLES - 1);

  phase_e        ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    ph_d   = ph_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (!sleep_n) begin
      ph_d   = PH_SLEEP;
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else begin
      unique case (ph_q)
        PH_SLEEP: begin
          ph_d   = PH_SETTLE;
          cnt_d  = '0;
          cnt_en = 1'b1;
        end
        PH_SETTLE: begin
          cnt_en = 1'b1;
          if (cnt_q == LAST) begin
            ph_d  = PH_RUN;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: ph_d = PH_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_SETTLE;
      cnt_q <= '0;
    end else begin
      ph_q <= ph_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign phase   = ph_q;
  assign pump_en = (ph_q != PH_SLEEP);

  // R3: a sleep request turns the charge pump off at the next edge
  p_pump_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_n |=> !pump_en);
  // R2: run is entered only from the last count of a settling window
  p_settle_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_RUN && $past(phase) != PH_RUN) |->
      ($past(phase) == PH_SETTLE && $past(cnt_q) == LAST));
  // R5: waking always restarts the window from zero
  p_wake_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SLEEP && sleep_n) |=> (phase == PH_SETTLE && cnt_q == '0));
endmodule

// File: rtl/mdrv_oc_latch.sv
// Combines the per-bridge overcurrent flags and latches a short-circuit fault.
module mdrv_oc_latch #(
  parameter int NUM_BRIDGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sleep_n,
  input  logic [NUM_BRIDGES-1:0] oc_flag,
  output logic                   any_oc,
  output logic                   latched
);
  logic [NUM_BRIDGES:0] or_chain;
  logic                 lat_q, lat_d;

  assign or_chain[0] = 1'b0;
  for (genvar b = 0; b < NUM_BRIDGES; b++) begin : g_or
    assign or_chain[b+1] = or_chain[b] | oc_flag[b];
  end
  assign any_oc = or_chain[NUM_BRIDGES];

  always_comb begin
    lat_d = lat_q;
    if (!sleep_n)    lat_d = 1'b0;
    else if (any_oc) lat_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat_q <= 1'b0;
    else        lat_q <= lat_d;
  end

  assign latched = lat_q;

  // R6: an overcurrent while awake is latched at the next edge
  p_oc_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_n && (oc_flag != '0)) |=> latched);
  // R7: the latch only drops through a sleep request
  p_oc_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (latched && sleep_n) |=> latched);
  // R7: a sleep request clears it
  p_oc_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_n |=> !latched);
endmodule

// File: rtl/mdrv_supervisor.sv
module mdrv_supervisor
  import mdrv_pkg::*;
#(
  parameter int NUM_BRIDGES   = 2,
  parameter int SETTLE_CYCLES = 20000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sleep_req_n,
  input  logic                   vbb_uv,
  input  logic                   vcp_uv,
  input  logic                   over_temp,
  input  logic [NUM_BRIDGES-1:0] oc_flag,
  output logic                   out_en,
  output logic                   pump_en,
  output logic                   stat_oc_latched,
  output logic                   stat_thermal,
  output logic                   stat_uv
);
  logic   srst_n;
  phase_e phase;
  logic   any_oc;
  logic   oc_lat;
  logic   uv_any;

  mdrv_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  mdrv_settle_seq #(.SETTLE_CYCLES(SETTLE_CYCLES)) i_seq (
    .clk     (clk),
    .rst_n   (srst_n),
    .sleep_n (sleep_req_n),
    .phase   (phase),
    .pump_en (pump_en)
  );

  mdrv_oc_latch #(.NUM_BRIDGES(NUM_BRIDGES)) i_oc (
    .clk     (clk),
    .rst_n   (srst_n),
    .sleep_n (sleep_req_n),
    .oc_flag (oc_flag),
    .any_oc  (any_oc),
    .latched (oc_lat)
  );

  assign uv_any = vbb_uv | vcp_uv;

  assign out_en = sleep_req_n && (phase == PH_RUN) && !oc_lat && !any_oc
                  && !uv_any && !over_temp;

  assign stat_oc_latched = oc_lat;
  assign stat_thermal    = over_temp;
  assign stat_uv         = uv_any;

  // R10: no enabled outputs while any gating fault is present
  p_gate_faults_r10: assert property (@(posedge clk) disable iff (!srst_n)
    out_en |-> (!stat_oc_latched && !stat_thermal && !stat_uv && pump_en));
  // R3: sleep request and enabled outputs never coexist
  p_sleep_off_r3: assert property (@(posedge clk) disable iff (!srst_n)
    !sleep_req_n |-> !out_en);
  // R1: reset leaves the overcurrent latch clear
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(srst_n) |-> !stat_oc_latched);
endmodule

// File: tb/test_mdrv_supervisor.sv
module test_mdrv_supervisor;
  localparam int NB = 2;
  localparam int ST = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sleep_req_n = 1'b1;
  logic          vbb_uv = 1'b0;
  logic          vcp_uv = 1'b0;
  logic          over_temp = 1'b0;
  logic [NB-1:0] oc_flag = '0;
  logic          out_en, pump_en, stat_oc_latched, stat_thermal, stat_uv;

  mdrv_supervisor #(.NUM_BRIDGES(NB), .SETTLE_CYCLES(ST)) i_mdrv_supervisor (
    .clk(clk), .rst_n(rst_n), .sleep_req_n(sleep_req_n), .vbb_uv(vbb_uv),
    .vcp_uv(vcp_uv), .over_temp(over_temp), .oc_flag(oc_flag),
    .out_en(out_en), .pump_en(pump_en), .stat_oc_latched(stat_oc_latched),
    .stat_thermal(stat_thermal), .stat_uv(stat_uv)
  );

  always #5 clk = ~clk;

  int    checks = 0;
  int    errors = 0;
  bit    done = 0;
  string req = "R1";

  // behavioural model: 0 asleep, 1 settling, 2 running
  int m_rel = 0;
  int m_ph  = 1;
  int m_cnt = 0;
  bit m_oc  = 0;

  task automatic cmp(input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_rel = 0; m_ph = 1; m_cnt = 0; m_oc = 0;
    end else if (m_rel < 2) begin
      m_rel++;
    end else begin
      if (!sleep_req_n)    m_oc = 0;
      else if (oc_flag != 0) m_oc = 1;
      if (!sleep_req_n) begin
        m_ph = 0; m_cnt = 0;
      end else if (m_ph == 0) begin
        m_ph = 1; m_cnt = 0;
      end else if (m_ph == 1) begin
        m_cnt++;
        if (m_cnt == ST) begin m_ph = 2; m_cnt = 0; end
      end
    end
    #2;
    if (!done) begin
      cmp("out_en", out_en, sleep_req_n && m_ph == 2 && !m_oc && oc_flag == 0
                            && !vbb_uv && !vcp_uv && !over_temp);
      cmp("pump_en", pump_en, m_ph != 0);
      cmp("stat_oc_latched", stat_oc_latched, m_oc);
      cmp("stat_thermal", stat_thermal, over_temp);
      cmp("stat_uv", stat_uv, vbb_uv | vcp_uv);
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    req = "R1";
    wait_cyc(3);
    rst_n = 1'b1;
    // R2: window plus two synchronizer edges, then run
    req = "R2";
    wait_cyc(ST + 6);
    cmp("R2 out_en high after settle", out_en, 1'b1);
    // R3 sleep entry
    req = "R3";
    sleep_req_n = 1'b0;
    #1 cmp("R3 out_en same cycle", out_en, 1'b0);
    wait_cyc(4);
    // R4 wake and settle again
    req = "R4";
    sleep_req_n = 1'b1;
    wait_cyc(ST + 3);
    // R5 sleep during the settle window
    req = "R5";
    sleep_req_n = 1'b0; wait_cyc(1);
    sleep_req_n = 1'b1; wait_cyc(6);
    sleep_req_n = 1'b0; wait_cyc(1);
    sleep_req_n = 1'b1; wait_cyc(ST + 3);
    // R6 overcurrent on each bridge
    req = "R6";
    oc_flag = 2'b01;
    #1 cmp("R6 out_en same cycle", out_en, 1'b0);
    wait_cyc(1); oc_flag = '0; wait_cyc(5);
    cmp("R6 latched after flag gone", stat_oc_latched, 1'b1);
    // R7 sleep clears; flags while asleep ignored
    req = "R7";
    sleep_req_n = 1'b0; wait_cyc(2);
    oc_flag = 2'b10; wait_cyc(3); oc_flag = '0;
    sleep_req_n = 1'b1; wait_cyc(ST + 3);
    cmp("R7 latch clear after sleep", stat_oc_latched, 1'b0);
    req = "R6";
    oc_flag = 2'b10; wait_cyc(1); oc_flag = '0; wait_cyc(3);
    // R7 reset clears the latch too
    req = "R7";
    rst_n = 1'b0; wait_cyc(2);
    cmp("R7 latch clear in reset", stat_oc_latched, 1'b0);
    rst_n = 1'b1; wait_cyc(ST + 4);
    // R8 thermal, not latched
    req = "R8";
    over_temp = 1'b1; wait_cyc(4); over_temp = 1'b0; wait_cyc(3);
    cmp("R8 recovered", out_en, 1'b1);
    // R9 undervoltage on either supply
    req = "R9";
    vbb_uv = 1'b1; wait_cyc(3); vbb_uv = 1'b0; wait_cyc(2);
    vcp_uv = 1'b1; wait_cyc(3); vcp_uv = 1'b0; wait_cyc(2);
    // R10 combinations
    req = "R10";
    vbb_uv = 1'b1; over_temp = 1'b1; wait_cyc(2);
    vbb_uv = 1'b0; wait_cyc(2); over_temp = 1'b0; wait_cyc(2);
    vcp_uv = 1'b1; sleep_req_n = 1'b0; wait_cyc(2);
    vcp_uv = 1'b0; sleep_req_n = 1'b1; wait_cyc(ST / 2);
    over_temp = 1'b1; wait_cyc(ST); over_temp = 1'b0; wait_cyc(4);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule